// File: doc/BRIEF.md
# DMA Channel Sequencer

This block is the control engine of a single DMA channel. Once it is enabled, it moves elements from a source address range to a destination address range, one element per granted clock. It counts elements within a frame, frames within a block, and, in packet mode, elements within a packet. A level-sensitive request line paces a synchronized channel. Synchronization can be per element, per frame or per packet, and each mode parks the channel at its own boundary until the next request edge.

At the end of a block the channel follows one of three policies:
- **Legacy:** disable, and optionally pulse a link output that names the next channel to start.
- **Auto-init reload:** reload and continue.
- **Park:** stop and wait until the end-program control bit is set.

The data path can also replace the source with a constant colour (fill) or drop writes whose value matches the colour (transparent copy). Sticky status bits report the frame, half-frame, last-frame, packet and block events. A one-cycle clear pulse resets them.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `chan_enabled`, `chan_active`, `chan_waiting`, `status`, `link_fire`, `mem_rd_req` and `mem_wr_req` are all 0.
- R2: One element completes on every clock edge where `chan_active` and `mem_grant` are both high, and on no other edge.
  - The read goes to `mem_rd_addr` and the write to `mem_wr_addr`.
  - Both addresses start at their programmed bases and advance by one per element.
  - With `mem_grant` low, the addresses hold.
- R3: A block holds exactly `cfg_elem_count` × `cfg_frame_count` elements. The element count and frame count are latched when the channel is loaded.
- R4: Status bit positions are: bit 0 end of block, bit 1 end of frame, bit 2 half frame, bit 3 last frame, bit 4 end of packet. Each bit is set only when the matching `cfg_irq_en` bit is 1.
  - Half frame is set when the element count within a frame reaches `cfg_elem_count`/2, rounded down.
  - Last frame is set when the first element of the final frame completes.
  - Bits stay set until a `clr_status` pulse.
- R5: In packet mode, a packet counter wraps every `cfg_pkt_count` elements. On each wrap it sets the end-of-packet bit, unless `cfg_src_sync` is 1.
- R6: A synchronized channel (`cfg_sync_id` ≠ 0) parks at a boundary set by its mode:
  - `cfg_fs`=0 and `cfg_bs`=0: after every element.
  - `cfg_fs`=1 and `cfg_bs`=0: after every frame.
  - `cfg_fs`=1 and `cfg_bs`=1: after every packet.
- R7: A synchronized channel does not park while `req_level` is high. A parked, enabled channel re-activates on a rising edge of `req_level`.
- R8: `cmd_enable` on a disabled channel does three things: it loads the bases and counts, it enables the channel, and it activates the channel on the same edge if the channel is unsynchronized or `req_level` is already high.
- R9: At the end of a block with `cfg_legacy_dis`=1, the channel disables itself. If `cfg_link_en`=1, it also raises `link_fire` for one cycle with `link_chan` equal to `cfg_link_target`.
- R10: At the end of a block with `cfg_legacy_dis`=0:
  - If `cfg_auto_init`=0, the channel disables.
  - If `cfg_repeat` or `cfg_end_prog` is 1, it reloads from the bases and keeps running.
- R11: With auto-init on and neither repeat nor end-program set, the end of a block raises `chan_waiting` and deactivates the channel. Setting `cfg_end_prog` then reloads the channel, clears the wait and re-activates it.
- R12: In fill mode the read strobe stays low and `cfg_color` is written. In transparent mode the write strobe stays low for any element whose value equals `cfg_color`.
- R13: `cmd_disable` clears the enabled, active and waiting states on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_enable | input | 1 | Enable pulse |
| cmd_disable | input | 1 | Disable pulse |
| clr_status | input | 1 | Clears sticky status |
| req_level | input | 1 | Level request line |
| cfg_sync_id | input | SYNC_W | Request number, 0 means unsynchronized |
| cfg_fs | input | 1 | Frame-sync flag |
| cfg_bs | input | 1 | Block/packet-sync flag |
| cfg_src_sync | input | 1 | Source-synchronized, masks end-of-packet |
| cfg_irq_en | input | 5 | Status enables, bit order as status |
| cfg_legacy_dis | input | 1 | Legacy end-of-block disable |
| cfg_auto_init | input | 1 | Auto-init enable |
| cfg_repeat | input | 1 | Repeat on auto-init |
| cfg_end_prog | input | 1 | End-program bit |
| cfg_link_en | input | 1 | Link enable |
| cfg_link_target | input | CH_W | Linked channel number |
| cfg_fill | input | 1 | Constant-fill mode |
| cfg_transparent | input | 1 | Transparent-copy mode |
| cfg_color | input | DATA_W | Colour value |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_elem_count | input | ELEM_W | Elements per frame |
| cfg_frame_count | input | FRAME_W | Frames per block |
| cfg_pkt_count | input | ELEM_W | Elements per packet |
| mem_grant | input | 1 | Memory port grant |
| mem_rd_data | input | DATA_W | Read data, same cycle |
| mem_rd_req | output | 1 | Read strobe |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_wr_req | output | 1 | Write strobe |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| chan_enabled | output | 1 | Channel enabled |
| chan_active | output | 1 | Channel moving data |
| chan_waiting | output | 1 | Parked for end-program |
| status | output | 5 | Sticky status bits |
| link_fire | output | 1 | One-cycle link start pulse |
| link_chan | output | CH_W | Channel to start |

## Verification
A wrong element, frame or packet counter shows up in two places. The address pattern shifts on the memory port within a frame, and a status bit is set on the wrong element, or the channel parks or disables early or late. This is visible on the very edge the boundary is crossed. A wrong activation state shows as strobes while the channel should be parked, or as silence on a rising request. The bench therefore counts granted elements, logs every write address and value, and compares the park points, the status value and the enabled, active and waiting flags after each phase against values derived from the block and frame sizes.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int STAT_W   = 5;
    localparam int ST_BLOCK = 0;
    localparam int ST_FRAME = 1;
    localparam int ST_HALF  = 2;
    localparam int ST_LAST  = 3;
    localparam int ST_PKT   = 4;

    typedef enum logic [1:0] {
        SYNC_ELEM  = 2'd0,
        SYNC_FRAME = 2'd1,
        SYNC_PKT   = 2'd2,
        SYNC_NONE  = 2'd3
    } sync_mode_e;

    typedef struct packed {
        logic step;
        logic frame_end;
        logic block_end;
        logic half_hit;
        logic last_hit;
        logic pkt_end;
    } seq_evt_t;

    function automatic sync_mode_e decode_sync(input logic synced, input logic fs, input logic bs);
        sync_mode_e m;
        if (!synced)            m = SYNC_NONE;
        else if (!fs && !bs)    m = SYNC_ELEM;
        else if (fs && !bs)     m = SYNC_FRAME;
        else if (fs && bs)      m = SYNC_PKT;
        else                    m = SYNC_NONE;
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] evt_to_status(input seq_evt_t e,
                                                        input logic [STAT_W-1:0] en,
                                                        input logic src_sync);
        logic [STAT_W-1:0] s;
        s = '0;
        s[ST_BLOCK] = e.block_end;
        s[ST_FRAME] = e.frame_end;
        s[ST_HALF]  = e.half_hit;
        s[ST_LAST]  = e.last_hit;
        s[ST_PKT]   = e.pkt_end && !src_sync;
        return s & en;
    endfunction

endpackage

// File: rtl/dma_seq_counters.sv
module dma_seq_counters
    import dma_seq_pkg::*;
#(
    parameter int ELEM_W  = 8,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic               pkt_on,
    input  logic [ELEM_W-1:0]  ld_elems,
    input  logic [FRAME_W-1:0] ld_frames,
    input  logic [ELEM_W-1:0]  ld_pkts,
    output seq_evt_t           evt
);

    localparam logic [ELEM_W:0] ONE_E = 1;

    logic [ELEM_W-1:0]  elem_q, pkt_q, n_elem_q, n_pkt_q;
    logic [FRAME_W-1:0] frame_q, n_frame_q;
    logic [ELEM_W:0]    elem_nx, pkt_nx;
    logic [FRAME_W:0]   frame_nx;

    always_comb begin
        elem_nx       = {1'b0, elem_q} + ONE_E;
        pkt_nx        = {1'b0, pkt_q} + ONE_E;
        frame_nx      = {1'b0, frame_q} + {{FRAME_W{1'b0}}, 1'b1};
        evt.step      = step;
        evt.frame_end = step && (elem_nx == {1'b0, n_elem_q});
        evt.block_end = evt.frame_end && (frame_nx == {1'b0, n_frame_q});
        evt.half_hit  = step && (elem_nx == {1'b0, n_elem_q >> 1});
        evt.last_hit  = step && (elem_nx == ONE_E) && (frame_nx == {1'b0, n_frame_q});
        evt.pkt_end   = step && pkt_on && (pkt_nx == {1'b0, n_pkt_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_q    <= '0;
            frame_q   <= '0;
            pkt_q     <= '0;
            n_elem_q  <= '0;
            n_frame_q <= '0;
            n_pkt_q   <= '0;
        end else if (load) begin
            elem_q    <= '0;
            frame_q   <= '0;
            pkt_q     <= '0;
            n_elem_q  <= ld_elems;
            n_frame_q <= ld_frames;
            n_pkt_q   <= ld_pkts;
        end else if (step) begin
            if (evt.frame_end) begin
                elem_q  <= '0;
                frame_q <= evt.block_end ? '0 : frame_nx[FRAME_W-1:0];
            end else begin
                elem_q  <= elem_nx[ELEM_W-1:0];
            end
            if (pkt_on)
                pkt_q <= evt.pkt_end ? '0 : pkt_nx[ELEM_W-1:0];
        end
    end

    assert_frame_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (n_frame_q != '0) |-> (frame_q < n_frame_q));

    assert_elem_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_end && !load) |=> (elem_q == '0));

    assert_pkt_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.pkt_end && !load) |=> (pkt_q == '0));

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              active,
    input  logic              fill,
    input  logic              transparent,
    input  logic [DATA_W-1:0] color,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [DATA_W-1:0] value;
    logic              drop;

    always_comb begin
        value   = fill ? color : rd_data;
        drop    = transparent && (value == color);
        rd_req  = active && !fill;
        wr_req  = active && !drop;
        rd_addr = src_q;
        wr_addr = dst_q;
        wr_data = value;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (load) begin
            src_q <= src_base;
            dst_q <= dst_base;
        end else if (step) begin
            src_q <= src_q + ADDR_W'(1);
            dst_q <= dst_q + ADDR_W'(1);
        end
    end

    assert_src_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (src_q == $past(src_q) + ADDR_W'(1)));

    assert_dst_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (dst_q == $past(dst_q) + ADDR_W'(1)));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(dst_q));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int SYNC_W = 5,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              clr_status,
    input  logic              req_level,
    input  logic              mem_grant,
    input  logic [SYNC_W-1:0] sync_id,
    input  logic              fs,
    input  logic              bs,
    input  logic              src_sync,
    input  logic [STAT_W-1:0] irq_en,
    input  logic              legacy_dis,
    input  logic              auto_init,
    input  logic              repeat_en,
    input  logic              end_prog,
    input  logic              link_en,
    input  logic [CH_W-1:0]   link_target,
    input  seq_evt_t          evt,
    output logic              step,
    output logic              load,
    output logic              pkt_on,
    output logic              enabled,
    output logic              active,
    output logic              waiting,
    output logic [STAT_W-1:0] status,
    output logic              link_fire,
    output logic [CH_W-1:0]   link_chan
);

    logic              en_q, act_q, wait_q, req_q, link_q;
    logic              en_d, act_d, wait_d, link_d;
    logic [STAT_W-1:0] status_q;
    logic [CH_W-1:0]   link_chan_q;
    logic              synced, park_hit, run_on;
    sync_mode_e        mode;

    always_comb begin
        synced   = |sync_id;
        mode     = decode_sync(synced, fs, bs);
        pkt_on   = fs && bs;
        step     = act_q && mem_grant;
        run_on   = !synced || req_level;
        park_hit = evt.step && ((mode == SYNC_ELEM) ||
                                (mode == SYNC_FRAME && evt.frame_end) ||
                                (mode == SYNC_PKT && evt.pkt_end));
        en_d   = en_q;
        act_d  = act_q;
        wait_d = wait_q;
        load   = 1'b0;
        link_d = 1'b0;
        if (cmd_disable) begin
            en_d   = 1'b0;
            act_d  = 1'b0;
            wait_d = 1'b0;
        end else if (!en_q) begin
            if (cmd_enable) begin
                en_d  = 1'b1;
                load  = 1'b1;
                act_d = run_on;
            end
        end else if (wait_q) begin
            if (end_prog) begin
                wait_d = 1'b0;
                load   = 1'b1;
                act_d  = run_on;
            end
        end else if (evt.block_end) begin
            if (legacy_dis) begin
                en_d   = 1'b0;
                act_d  = 1'b0;
                link_d = link_en;
            end else if (!auto_init) begin
                en_d  = 1'b0;
                act_d = 1'b0;
            end else if (repeat_en || end_prog) begin
                load = 1'b1;
                if (park_hit && !req_level)
                    act_d = 1'b0;
            end else begin
                wait_d = 1'b1;
                act_d  = 1'b0;
                load   = 1'b1;
            end
        end else if (park_hit && !req_level) begin
            act_d = 1'b0;
        end else if (!act_q && synced && req_level && !req_q) begin
            act_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            act_q       <= 1'b0;
            wait_q      <= 1'b0;
            req_q       <= 1'b0;
            link_q      <= 1'b0;
            link_chan_q <= '0;
            status_q    <= '0;
        end else begin
            en_q     <= en_d;
            act_q    <= act_d;
            wait_q   <= wait_d;
            req_q    <= req_level;
            link_q   <= link_d;
            if (link_d)
                link_chan_q <= link_target;
            status_q <= (clr_status ? '0 : status_q) | evt_to_status(evt, irq_en, src_sync);
        end
    end

    assign enabled   = en_q;
    assign active    = act_q;
    assign waiting   = wait_q;
    assign status    = status_q;
    assign link_fire = link_q;
    assign link_chan = link_chan_q;

    assert_disable_stops_R13: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> (!act_q && !en_q && !wait_q));

    assert_wait_idle_R11: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> !act_q);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (act_q && synced && req_level && !cmd_disable && !evt.block_end) |=> act_q);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_status |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_active_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        act_q |-> en_q);

    assert_link_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        link_q |-> !en_q);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int ELEM_W  = 8,
    parameter int FRAME_W = 8,
    parameter int SYNC_W  = 5,
    parameter int CH_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_enable,
    input  logic               cmd_disable,
    input  logic               clr_status,
    input  logic               req_level,
    input  logic [SYNC_W-1:0]  cfg_sync_id,
    input  logic               cfg_fs,
    input  logic               cfg_bs,
    input  logic               cfg_src_sync,
    input  logic [4:0]         cfg_irq_en,
    input  logic               cfg_legacy_dis,
    input  logic               cfg_auto_init,
    input  logic               cfg_repeat,
    input  logic               cfg_end_prog,
    input  logic               cfg_link_en,
    input  logic [CH_W-1:0]    cfg_link_target,
    input  logic               cfg_fill,
    input  logic               cfg_transparent,
    input  logic [DATA_W-1:0]  cfg_color,
    input  logic [ADDR_W-1:0]  cfg_src_base,
    input  logic [ADDR_W-1:0]  cfg_dst_base,
    input  logic [ELEM_W-1:0]  cfg_elem_count,
    input  logic [FRAME_W-1:0] cfg_frame_count,
    input  logic [ELEM_W-1:0]  cfg_pkt_count,
    input  logic               mem_grant,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic               mem_wr_req,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0]  mem_wr_data,
    output logic               chan_enabled,
    output logic               chan_active,
    output logic               chan_waiting,
    output logic [4:0]         status,
    output logic               link_fire,
    output logic [CH_W-1:0]    link_chan
);

    seq_evt_t evt;
    logic     step, load, pkt_on;

    dma_seq_ctrl #(.SYNC_W(SYNC_W), .CH_W(CH_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .clr_status(clr_status),
        .req_level(req_level), .mem_grant(mem_grant),
        .sync_id(cfg_sync_id), .fs(cfg_fs), .bs(cfg_bs), .src_sync(cfg_src_sync),
        .irq_en(cfg_irq_en), .legacy_dis(cfg_legacy_dis), .auto_init(cfg_auto_init),
        .repeat_en(cfg_repeat), .end_prog(cfg_end_prog), .link_en(cfg_link_en),
        .link_target(cfg_link_target), .evt(evt),
        .step(step), .load(load), .pkt_on(pkt_on),
        .enabled(chan_enabled), .active(chan_active), .waiting(chan_waiting),
        .status(status), .link_fire(link_fire), .link_chan(link_chan)
    );

    dma_seq_counters #(.ELEM_W(ELEM_W), .FRAME_W(FRAME_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .step(step), .pkt_on(pkt_on),
        .ld_elems(cfg_elem_count), .ld_frames(cfg_frame_count), .ld_pkts(cfg_pkt_count),
        .evt(evt)
    );

    dma_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .load(load), .step(step), .active(chan_active),
        .fill(cfg_fill), .transparent(cfg_transparent), .color(cfg_color),
        .src_base(cfg_src_base), .dst_base(cfg_dst_base), .rd_data(mem_rd_data),
        .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
        .wr_req(mem_wr_req), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
    );

endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;

    localparam logic [15:0] SRC = 16'h0010;
    localparam logic [15:0] DST = 16'h0100;

    // vector: [33:26] elems, [25:18] frames, [17] fill, [16] transparent, [15:0] colour
    localparam logic [33:0] VECS [0:5] = '{
        {8'd4, 8'd3, 1'b0, 1'b0, 16'h0000},
        {8'd5, 8'd2, 1'b0, 1'b0, 16'h0000},
        {8'd1, 8'd4, 1'b0, 1'b0, 16'h0000},
        {8'd3, 8'd2, 1'b1, 1'b0, 16'hBEEF},
        {8'd6, 8'd1, 1'b0, 1'b1, 16'h5A12},
        {8'd2, 8'd2, 1'b1, 1'b1, 16'h7777}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_enable = 0, cmd_disable = 0, clr_status = 0, req_level = 0;
    logic [4:0]  cfg_sync_id = 0;
    logic cfg_fs = 0, cfg_bs = 0, cfg_src_sync = 0;
    logic [4:0]  cfg_irq_en = 5'h1F;
    logic cfg_legacy_dis = 0, cfg_auto_init = 0, cfg_repeat = 0, cfg_end_prog = 0;
    logic cfg_link_en = 0;
    logic [3:0]  cfg_link_target = 0;
    logic cfg_fill = 0, cfg_transparent = 0;
    logic [15:0] cfg_color = 0, cfg_src_base = SRC, cfg_dst_base = DST;
    logic [7:0]  cfg_elem_count = 1, cfg_frame_count = 1, cfg_pkt_count = 1;
    logic        mem_grant = 1;
    logic [15:0] mem_rd_data;
    logic        mem_rd_req, mem_wr_req;
    logic [15:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic        chan_enabled, chan_active, chan_waiting, link_fire;
    logic [4:0]  status;
    logic [3:0]  link_chan;

    int total = 0, bad = 0, cyc = 0;
    int elem_seen = 0, wr_cnt = 0, rd_cnt = 0, link_seen = 0;
    logic [3:0]  link_val;
    logic [15:0] wr_addr_log [0:63];
    logic [15:0] wr_data_log [0:63];

    always #4 clk = ~clk;

    assign mem_rd_data = {8'h5A, mem_rd_addr[7:0]};

    dma_chan_seq u_dut (
        .clk(clk), .rst(rst), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .clr_status(clr_status), .req_level(req_level), .cfg_sync_id(cfg_sync_id),
        .cfg_fs(cfg_fs), .cfg_bs(cfg_bs), .cfg_src_sync(cfg_src_sync), .cfg_irq_en(cfg_irq_en),
        .cfg_legacy_dis(cfg_legacy_dis), .cfg_auto_init(cfg_auto_init), .cfg_repeat(cfg_repeat),
        .cfg_end_prog(cfg_end_prog), .cfg_link_en(cfg_link_en), .cfg_link_target(cfg_link_target),
        .cfg_fill(cfg_fill), .cfg_transparent(cfg_transparent), .cfg_color(cfg_color),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base), .cfg_elem_count(cfg_elem_count),
        .cfg_frame_count(cfg_frame_count), .cfg_pkt_count(cfg_pkt_count),
        .mem_grant(mem_grant), .mem_rd_data(mem_rd_data), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .chan_enabled(chan_enabled), .chan_active(chan_active),
        .chan_waiting(chan_waiting), .status(status), .link_fire(link_fire), .link_chan(link_chan)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (chan_active && mem_grant) begin
                elem_seen++;
                if (mem_rd_req) rd_cnt++;
                if (mem_wr_req) begin
                    if (wr_cnt < 64) begin
                        wr_addr_log[wr_cnt] = mem_wr_addr;
                        wr_data_log[wr_cnt] = mem_wr_data;
                    end
                    wr_cnt++;
                end
            end
            if (link_fire) begin
                link_seen++;
                link_val = link_chan;
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog actual=%0d expected<%0d cycles", cyc, 100000);
            summary();
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_logs();
        elem_seen = 0; wr_cnt = 0; rd_cnt = 0; link_seen = 0;
        clr_status = 1; tick(1); clr_status = 0;
    endtask

    task automatic pulse_enable();
        cmd_enable = 1; tick(1); cmd_enable = 0;
    endtask

    task automatic wait_idle(input int lim);
        for (int i = 0; i < lim && chan_enabled; i++) tick(1);
        tick(2);
    endtask

    task automatic base_cfg();
        cfg_sync_id = 0; cfg_fs = 0; cfg_bs = 0; cfg_src_sync = 0; cfg_irq_en = 5'h1F;
        cfg_legacy_dis = 0; cfg_auto_init = 0; cfg_repeat = 0; cfg_end_prog = 0;
        cfg_link_en = 0; cfg_fill = 0; cfg_transparent = 0; cfg_color = 0;
        cfg_src_base = SRC; cfg_dst_base = DST; cfg_pkt_count = 1; req_level = 0; mem_grant = 1;
    endtask

    initial begin
        logic [33:0] w;
        logic [15:0] val;
        logic [4:0]  exp_st;
        int n, exp_wr, j, log_bad;
        logic [15:0] addr_hold;

        tick(3);
        rst = 0;
        tick(1);
        // R1: reset state
        check("R1", "enabled", chan_enabled, 0);
        check("R1", "active", chan_active, 0);
        check("R1", "waiting", chan_waiting, 0);
        check("R1", "status", status, 0);
        check("R1", "strobes", {mem_rd_req, mem_wr_req, link_fire}, 0);

        // table walk: unsynchronized whole blocks
        for (int v = 0; v < 6; v++) begin
            w = VECS[v];
            base_cfg();
            cfg_elem_count = w[33:26]; cfg_frame_count = w[25:18];
            cfg_fill = w[17]; cfg_transparent = w[16]; cfg_color = w[15:0];
            clear_logs();
            pulse_enable();
            wait_idle(200);
            n = int'(w[33:26]) * int'(w[25:18]);
            exp_wr = 0; j = 0; log_bad = 0;
            for (int k = 0; k < n; k++) begin
                val = w[17] ? w[15:0] : {8'h5A, 8'(SRC + 16'(k))};
                if (!w[16] || val != w[15:0]) begin
                    if (j < 64 && (wr_addr_log[j] != DST + 16'(k) || wr_data_log[j] != val)) log_bad = 1;
                    j++;
                    exp_wr++;
                end
            end
            exp_st = {1'b0, 1'b1, (w[33:26] >= 8'd2), 1'b1, 1'b1};
            check("R3", "elements per block", elem_seen, n);
            check("R12", "read strobes", rd_cnt, w[17] ? 0 : n);
            check("R12", "write strobes", wr_cnt, exp_wr);
            check("R2", "write addr/data log", log_bad, 0);
            check("R4", "status after block", status, exp_st);
            check("R10", "auto-init off disables", chan_enabled, 0);
        end
        clr_status = 1; tick(1); clr_status = 0;
        check("R4", "clear pulse", status, 0);

        // element sync: park after each element, request hold
        base_cfg();
        cfg_sync_id = 5'd1; cfg_elem_count = 6; cfg_frame_count = 1;
        clear_logs();
        pulse_enable();
        tick(2);
        check("R8", "sync enable with low request stays idle", {chan_enabled, chan_active}, 2'b10);
        check("R8", "no element while idle", elem_seen, 0);
        req_level = 1; tick(1); req_level = 0; tick(3);
        check("R6", "element sync one element per edge", elem_seen, 1);
        check("R6", "element sync parked", {chan_enabled, chan_active}, 2'b10);
        req_level = 1; tick(3); req_level = 0; tick(3);
        check("R7", "held request keeps running", elem_seen, 4);
        check("R7", "park after request drop", chan_active, 0);
        cmd_disable = 1; tick(1); cmd_disable = 0;
        check("R13", "disable clears state", {chan_enabled, chan_active, chan_waiting}, 3'b000);

        // frame sync
        base_cfg();
        cfg_sync_id = 5'd3; cfg_fs = 1; cfg_elem_count = 3; cfg_frame_count = 2;
        clear_logs();
        req_level = 1;
        pulse_enable();
        check("R8", "sync enable with high request activates", chan_active, 1);
        req_level = 0; tick(5);
        check("R6", "frame sync elements", elem_seen, 3);
        check("R6", "frame sync parked", {chan_enabled, chan_active}, 2'b10);
        check("R4", "frame+half status", status, 5'b00110);
        req_level = 1; tick(1); req_level = 0; tick(5);
        check("R3", "frame sync block total", elem_seen, 6);
        check("R3", "frame sync block done", chan_enabled, 0);
        check("R4", "final status", status, 5'b01111);

        // packet sync
        base_cfg();
        cfg_sync_id = 5'd2; cfg_fs = 1; cfg_bs = 1; cfg_elem_count = 4; cfg_frame_count = 1;
        cfg_pkt_count = 2;
        clear_logs();
        req_level = 1;
        pulse_enable();
        req_level = 0; tick(5);
        check("R6", "packet sync elements", elem_seen, 2);
        check("R6", "packet sync parked", chan_active, 0);
        check("R5", "packet status", status, 5'b11100);
        clr_status = 1; tick(1); clr_status = 0;
        check("R4", "clear mid block", status, 0);
        cfg_src_sync = 1;
        req_level = 1; tick(1); req_level = 0; tick(5);
        check("R5", "source sync masks packet bit", status, 5'b00011);
        check("R5", "packet block total", elem_seen, 4);

        // legacy disable with link
        base_cfg();
        cfg_elem_count = 2; cfg_frame_count = 1;
        cfg_legacy_dis = 1; cfg_link_en = 1; cfg_link_target = 4'd5;
        clear_logs();
        pulse_enable();
        tick(6);
        check("R9", "link pulse count", link_seen, 1);
        check("R9", "link channel", link_val, 5);
        check("R9", "legacy disable", chan_enabled, 0);

        // auto-init repeat, grant gating
        base_cfg();
        cfg_elem_count = 2; cfg_frame_count = 1; cfg_auto_init = 1; cfg_repeat = 1;
        clear_logs();
        pulse_enable();
        tick(8);
        check("R10", "repeat reload addr", wr_addr_log[2], DST);
        check("R10", "repeat second addr", wr_addr_log[3], DST + 16'd1);
        check("R10", "repeat keeps enabled", {chan_enabled, chan_active}, 2'b11);
        mem_grant = 0; tick(1);
        addr_hold = mem_wr_addr;
        tick(4);
        check("R2", "no advance without grant", mem_wr_addr, addr_hold);
        mem_grant = 1;
        cmd_disable = 1; tick(1); cmd_disable = 0;
        check("R13", "disable while running", {chan_enabled, chan_active}, 2'b00);

        // auto-init waiting for end-program
        base_cfg();
        cfg_elem_count = 3; cfg_frame_count = 1; cfg_auto_init = 1;
        clear_logs();
        pulse_enable();
        tick(6);
        check("R11", "elements before wait", elem_seen, 3);
        check("R11", "waiting state", {chan_enabled, chan_active, chan_waiting}, 3'b101);
        cfg_end_prog = 1; tick(1);
        check("R11", "resume on end-program", {chan_active, chan_waiting}, 2'b10);
        tick(2);
        check("R11", "resume from base", wr_addr_log[3], DST);
        cfg_auto_init = 0; cfg_end_prog = 0;
        wait_idle(50);
        check("R10", "auto-init off ends", chan_enabled, 0);

        summary();
    end

endmodule